// File: doc/BRIEF.md
# Edge-Latched Static Memory Core

This block models a small static memory whose cycles are framed by an active-low enable strobe rather than by a clock. A fast system clock samples every pin through a synchronizer. Each sample is compared with the one before it to find strobe edges. When the enable strobe falls, the block captures the address and a high-order select input. The cycle then proceeds under the captured values, so the address and select pins are free to move.

Reads place the addressed word in an output latch. The latch follows the array while the strobe is low and freezes when the strobe rises. It holds that word until the next falling edge. Writes are qualified by the strobe, the write-enable and a second select all being low, with the captured select also low. The stored word follows the data input until the first of those three controls rises.

Because the output enable drops whenever write-enable is low, the data-in and data-out pins can share one bus. Between cycles the live select inputs decide whether the frozen word is still driven.

Top module: `latched_sram_core`

## Requirements
- R1: While reset is asserted, and after it is released with the chip-select pin high, `dout_en` is 0 and `dout` is 0.
- R2: A falling edge of `ce_n` captures `addr` and `bank_sel`. Later changes on those pins during the same low period change neither the word read nor the drive decision.
- R3: If `bank_sel` was captured high, the cycle writes nothing and `dout_en` stays 0 for the whole low period of `ce_n`, whatever the live `bank_sel` does.
- R4: With `ce_n` low, `cs_n` low, `we_n` high and `bank_sel` captured low, `dout_en` is 1 and `dout` equals the word stored at the captured address.
- R5: A rising edge of `ce_n` freezes `dout`. It keeps that value, even when the address pins change, until `ce_n` falls again.
- R6: While `ce_n` is high, the live `bank_sel` and `cs_n` decide the drive: `dout_en` is 1 only when both are low and `we_n` is high.
- R7: A write is active while `ce_n`, `we_n` and `cs_n` are low and the captured `bank_sel` is low. The last `din` value before the first rise of `ce_n`, `we_n` or `cs_n` is the value kept. Later `din` changes are ignored.
- R8: Whenever `we_n` is low, `dout_en` is 0.
- R9: `we_n` may stay low across consecutive `ce_n` cycles, and each cycle writes its own captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low cycle strobe; falling edge captures address and bank select |
| we_n | input | 1 | Active-low write enable; low also disables the output |
| cs_n | input | 1 | Active-low live chip select |
| bank_sel | input | 1 | Active-low high-order select, captured at strobe fall and live between cycles |
| addr | input | ADDR_W (8) | Word address |
| din | input | DATA_W (4) | Write data |
| dout | output | DATA_W (4) | Latched read data |
| dout_en | output | 1 | Output drive enable; 0 means high impedance |

## Verification
A write and the drive decision can meet in the same cycle. The bench provokes this by dropping `we_n` while a read cycle is driving, and by holding it low across a whole sweep of back-to-back writes. It judges the outcome by requiring `dout_en` to be 0 throughout and the read-back word to be the final `din`. A termination and a read can also coincide. In that case `we_n` rises mid-cycle with `ce_n` still low. The bench then expects the output to switch on at once with the word that was just written, and it expects later `din` changes not to reach the array.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;

   typedef struct packed {
      logic strobe_n;
      logic wr_n;
      logic chip_n;
      logic bank;
   } ctrl_pins_t;

   localparam ctrl_pins_t CTRL_IDLE = '{strobe_n: 1'b1, wr_n: 1'b1, chip_n: 1'b1, bank: 1'b1};

   typedef enum logic {
      PH_IDLE   = 1'b0,
      PH_ACTIVE = 1'b1
   } cyc_phase_t;

endpackage

// File: rtl/sram_pin_sync.sv
module sram_pin_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= RST_VAL;
               else        stage_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[i] <= RST_VAL;
               else        stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sram_cycle_ctl.sv
module sram_cycle_ctl
   import sram_core_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctrl_pins_t        ctrl,
   input  logic [ADDR_W-1:0] addr_s,
   output logic [ADDR_W-1:0] addr_lat,
   output logic              bank_lat,
   output logic              strobe_fall,
   output logic              cyc_active,
   output logic              wr_en,
   output logic              load_q,
   output logic              oe_next
);

   logic       strobe_prev;
   cyc_phase_t phase;
   logic       bank_eff;

   assign strobe_fall = strobe_prev & ~ctrl.strobe_n;
   assign cyc_active  = (phase == PH_ACTIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_prev <= 1'b1;
         phase       <= PH_IDLE;
         addr_lat    <= '0;
         bank_lat    <= 1'b1;
      end else begin
         strobe_prev <= ctrl.strobe_n;
         if (strobe_fall) begin
            phase    <= PH_ACTIVE;
            addr_lat <= addr_s;
            bank_lat <= ctrl.bank;
         end else if (ctrl.strobe_n) begin
            phase <= PH_IDLE;
         end
      end
   end

   assign wr_en    = cyc_active & ~ctrl.strobe_n & ~ctrl.wr_n & ~ctrl.chip_n & ~bank_lat;
   assign load_q   = cyc_active & ~ctrl.strobe_n;
   assign bank_eff = cyc_active ? bank_lat : ctrl.bank;
   assign oe_next  = ~ctrl.chip_n & ctrl.wr_n & ~bank_eff;

endmodule

// File: rtl/sram_word_store.sv
module sram_word_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_q,
   input  logic              oe_next,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] q,
   output logic              q_en
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q    <= '0;
         q_en <= 1'b0;
      end else begin
         if (load_q) q <= rdata;
         q_en <= oe_next;
      end
   end

endmodule

// File: rtl/latched_sram_core.sv
module latched_sram_core
   import sram_core_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              cs_n,
   input  logic              bank_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   localparam int BUS_W = ADDR_W + DATA_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("latched_sram_core: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("latched_sram_core: DATA_W must be positive");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("latched_sram_core: SYNC_STAGES must be at least 2");
      end
   endgenerate

   ctrl_pins_t        ctrl_raw;
   ctrl_pins_t        ctrl_s;
   logic [BUS_W-1:0]  bus_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] din_s;
   logic [ADDR_W-1:0] addr_lat;
   logic              bank_lat;
   logic              strobe_fall;
   logic              cyc_active;
   logic              wr_en;
   logic              load_q;
   logic              oe_next;
   logic [DATA_W-1:0] rdata;
   logic              e_s;
   logic              s1_s;

   assign ctrl_raw = '{strobe_n: ce_n, wr_n: we_n, chip_n: cs_n, bank: bank_sel};

   sram_pin_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
      .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s)
   );

   sram_pin_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(bus_s)
   );

   assign addr_s = bus_s[BUS_W-1:DATA_W];
   assign din_s  = bus_s[DATA_W-1:0];
   assign e_s    = ctrl_s.strobe_n;
   assign s1_s   = ctrl_s.chip_n;

   sram_cycle_ctl #(.ADDR_W(ADDR_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl_s), .addr_s(addr_s),
      .addr_lat(addr_lat), .bank_lat(bank_lat), .strobe_fall(strobe_fall),
      .cyc_active(cyc_active), .wr_en(wr_en), .load_q(load_q), .oe_next(oe_next)
   );

   sram_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .wr_en(wr_en), .addr(addr_lat), .wdata(din_s), .rdata(rdata)
   );

   sram_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .load_q(load_q), .oe_next(oe_next),
      .rdata(rdata), .q(dout), .q_en(dout_en)
   );

endmodule

// File: rtl/sram_core_checker.sv
module sram_core_checker #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              e_s,
   input logic              s1_s,
   input logic              strobe_fall,
   input logic              cyc_active,
   input logic              bank_lat,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr_lat,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en
);

   // R2: captured address only moves on a strobe fall
   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_fall |=> $stable(addr_lat));

   // R3: a cycle captured with bank select high never writes
   p_bank_high_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_active && bank_lat) |-> !wr_en);

   // R5: output word frozen while the strobe is high
   p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      e_s |=> $stable(dout));

   // R6: chip select high releases the output
   p_cs_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
      s1_s |=> !dout_en);

   // R8: an active write never leaves the output driven
   p_write_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !dout_en);

endmodule

bind latched_sram_core sram_core_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .e_s(e_s), .s1_s(s1_s), .strobe_fall(strobe_fall),
   .cyc_active(cyc_active), .bank_lat(bank_lat), .wr_en(wr_en),
   .addr_lat(addr_lat), .dout(dout), .dout_en(dout_en)
);

// File: tb/latched_sram_core_test.sv
module latched_sram_core_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW    = 8;
   localparam int DW    = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ce_n, we_n, cs_n, bank_sel;
   logic [AW-1:0] addr;
   logic [DW-1:0] din;
   logic [DW-1:0] dout;
   logic          dout_en;

   logic [DW-1:0] ref_mem [DEPTH];
   int            checks   = 0;
   int            failures = 0;
   bit            done     = 0;

   latched_sram_core #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cs_n(cs_n),
      .bank_sel(bank_sel), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (8) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [DW-1:0] pat(input int a, input int k);
      return DW'((a * 5 + k * 3 + 1) % 16);
   endfunction

   task automatic read_back(input int a, input string req);
      addr = AW'(a); we_n = 1'b1; cs_n = 1'b0; bank_sel = 1'b0;
      ce_n = 1'b0; settle();
      chk(req, {7'd0, dout_en}, 8'd1);
      chk(req, {4'd0, dout}, {4'd0, ref_mem[a]});
      ce_n = 1'b1; settle();
   endtask

   initial begin
      ce_n = 1'b1; we_n = 1'b1; cs_n = 1'b1; bank_sel = 1'b1;
      addr = '0; din = '0; rst_n = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R1 en in reset", {7'd0, dout_en}, 8'd0);
      chk("R1 dout in reset", {4'd0, dout}, 8'd0);
      rst_n = 1'b1;
      settle();
      chk("R1 en after reset", {7'd0, dout_en}, 8'd0);
      chk("R1 dout after reset", {4'd0, dout}, 8'd0);

      // R9 / R7: full sweep of writes with we_n held low, data rewritten mid-cycle
      we_n = 1'b0; cs_n = 1'b0; bank_sel = 1'b0;
      for (int a = 0; a < DEPTH; a++) begin
         addr = AW'(a);
         ce_n = 1'b0; settle();
         din = ~pat(a, 0); settle();
         din = pat(a, 0); settle();
         chk("R8 hiz during write", {7'd0, dout_en}, 8'd0);
         ce_n = 1'b1; settle();
         din = ~pat(a, 0);
         ref_mem[a] = pat(a, 0);
      end
      we_n = 1'b1;

      // R4 / R2 / R5 / R6: full read sweep
      for (int a = 0; a < DEPTH; a++) begin
         addr = AW'(a);
         ce_n = 1'b0; settle();
         chk("R4 read en", {7'd0, dout_en}, 8'd1);
         chk("R4 R9 read data", {4'd0, dout}, {4'd0, ref_mem[a]});
         addr = AW'(a ^ 8'h55); settle();
         chk("R2 addr moved", {4'd0, dout}, {4'd0, ref_mem[a]});
         ce_n = 1'b1; settle();
         chk("R5 frozen", {4'd0, dout}, {4'd0, ref_mem[a]});
         chk("R6 live drive", {7'd0, dout_en}, 8'd1);
      end

      // R6: live selects between cycles
      bank_sel = 1'b1; settle();
      chk("R6 bank high", {7'd0, dout_en}, 8'd0);
      bank_sel = 1'b0; settle();
      chk("R6 bank low", {7'd0, dout_en}, 8'd1);
      cs_n = 1'b1; settle();
      chk("R6 cs high", {7'd0, dout_en}, 8'd0);
      cs_n = 1'b0; we_n = 1'b0; settle();
      chk("R8 we low idle", {7'd0, dout_en}, 8'd0);
      we_n = 1'b1; settle();

      // R8: we_n dropped during a driving read cycle (cs_n high, so no write)
      addr = 8'd20; ce_n = 1'b0; settle();
      chk("R8 pre", {7'd0, dout_en}, 8'd1);
      cs_n = 1'b1; we_n = 1'b0; din = 4'hF; settle();
      chk("R8 we low in cycle", {7'd0, dout_en}, 8'd0);
      we_n = 1'b1; cs_n = 1'b0; settle();
      chk("R8 restored", {4'd0, dout}, {4'd0, ref_mem[20]});
      ce_n = 1'b1; settle();

      // R3: bank captured high
      bank_sel = 1'b1; addr = 8'd5; we_n = 1'b0; cs_n = 1'b0; din = ~ref_mem[5];
      ce_n = 1'b0; settle();
      chk("R3 en", {7'd0, dout_en}, 8'd0);
      bank_sel = 1'b0; settle();
      chk("R3 live bank low", {7'd0, dout_en}, 8'd0);
      we_n = 1'b1; settle();
      chk("R3 read blocked", {7'd0, dout_en}, 8'd0);
      ce_n = 1'b1; settle();
      read_back(5, "R3 no write");

      // R7: write ended by cs_n rise
      addr = 8'd9; cs_n = 1'b1; we_n = 1'b0; ce_n = 1'b0; settle();
      din = 4'hA; cs_n = 1'b0; settle();
      cs_n = 1'b1; settle();
      din = 4'h3; settle();
      ce_n = 1'b1; we_n = 1'b1; settle();
      ref_mem[9] = 4'hA;
      read_back(9, "R7 cs end");

      // R7: write ended by we_n rise, then read in same cycle
      addr = 8'd10; we_n = 1'b1; cs_n = 1'b0; ce_n = 1'b0; settle();
      we_n = 1'b0; din = 4'h6; settle();
      we_n = 1'b1; settle();
      din = 4'hC; settle();
      chk("R7 rw en", {7'd0, dout_en}, 8'd1);
      chk("R7 rw data", {4'd0, dout}, 8'h06);
      ce_n = 1'b1; settle();
      ref_mem[10] = 4'h6;
      read_back(10, "R7 we end");

      // R7: write ended by ce_n rise, later din ignored
      addr = 8'd11; we_n = 1'b0; ce_n = 1'b0; settle();
      din = 4'h2; settle();
      ce_n = 1'b1; settle();
      din = 4'h8; settle();
      we_n = 1'b1;
      ref_mem[11] = 4'h2;
      read_back(11, "R7 ce end");

      // R2: bank pin change after capture
      addr = 8'd3; bank_sel = 1'b0; ce_n = 1'b0; settle();
      bank_sel = 1'b1; settle();
      chk("R2 bank captured", {7'd0, dout_en}, 8'd1);
      chk("R2 data", {4'd0, dout}, {4'd0, ref_mem[3]});
      ce_n = 1'b1; settle();
      chk("R6 live bank after rise", {7'd0, dout_en}, 8'd0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule